// File: doc/BRIEF.md
# Two-Wire Slave Register-File Port

This block is a serial slave on a two-wire bus. It lets a bus master reach a 64-byte address space. Bytes 0 to 7 hold the clock-calendar and control registers, and bytes 8 to 63 are general RAM. The registers themselves live outside the block. The block reaches them through a write stream and a read stream, each with a valid/ready handshake. Both bus lines are oversampled by the system clock. START and STOP are found from SDA edges that occur while SCL is high. The block answers only to the 7-bit device address 1101000.

A write transaction has three parts: the device address with R/W=0, one byte that loads the internal pointer, and then data bytes. Each data byte goes out on the write stream at the pointer and is acknowledged. A read transaction (R/W=1) returns bytes starting at the current pointer. It continues until the master refuses a byte. The pointer advances once per byte moved, in either direction, and wraps at the top of the space. A power-fail input aborts everything, clears the pointer and makes the block deaf to the bus while it is high.

Back-pressure rules: a request (`wr_valid` or `rd_valid`) stays up with its address and data unchanged until the matching ready is seen high at a clock edge. The transfer happens in that cycle; for reads, `rd_data` is taken in that same cycle. The bus is never stretched. The register file must therefore accept a write before the next byte completes, and answer a read within half an SCL bit time.

Top module: `twi_regfile_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins address matching. A rising SDA while SCL is high (STOP) returns the block to idle, where clocked bytes are neither acknowledged nor acted on.
- R2: A first byte whose upper seven bits equal 1101000 is acknowledged by pulling SDA low for the ninth clock. Any other first byte gets no acknowledge, and the block stays silent until the next START.
- R3: In a write (first byte bit 0 = 0), the second byte sets the pointer to its low 6 bits and is acknowledged.
- R4: Each later byte of a write is presented on the write stream with `wr_addr` equal to the pointer, and is acknowledged. The pointer then increases by one.
- R5: In a read (first byte bit 0 = 1), bytes are fetched from the pointer onward through the read stream. Each byte is shifted out MSB first, and the pointer increases by one per fetched byte.
- R6: When the master does not acknowledge a read byte, the block releases SDA and fetches nothing more. It drives nothing until the next START or STOP.
- R7: The pointer wraps from 63 to 0.
- R8: A repeated START in the middle of a transaction restarts address matching. The pointer keeps its value, so a read can follow a pointer-setting write.
- R9: While `pwr_fail` is high, the block cancels pending requests, clears the pointer to 0, releases SDA and ignores all bus activity. One cycle after it rises, these effects are visible.
- R10: `wr_valid` and `rd_valid` are never high together. Each is held, with its address and data stable, until its ready is sampled high.
- R11: SDA is only pulled low, through `sda_oe` = 1. Apart from a power-fail release, `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blocks access |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Register file accepts the write |
| wr_addr | output | 6 | Write address (the pointer) |
| wr_data | output | 8 | Write data |
| rd_valid | output | 1 | Read request pending |
| rd_ready | input | 1 | Register file returns data this cycle |
| rd_addr | output | 6 | Read address (the pointer) |
| rd_data | input | 8 | Read data, taken when `rd_valid` and `rd_ready` are both high |

## Verification
The interesting collision is a power failure that lands while a write request is still waiting for `wr_ready`. The bench causes it by holding the register file's ready low after a data byte has been acknowledged, then raising `pwr_fail` with the request still pending. The abort must win. The request must drop without a transfer, and the target byte in the register file must keep its old value. A read issued after power returns must start at address 0. That shows the pointer clear was not undone by a late increment.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } twi_st_e;
endpackage

// File: rtl/twi_line_mon.sv
`timescale 1ns/1ps
module twi_line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_i};
      sda_p <= {sda_p[SYNC-1:0], sda_i};
    end
  end

  assign scl_now = scl_p[SYNC-1];
  assign scl_old = scl_p[SYNC];
  assign sda_s   = sda_p[SYNC-1];
  assign sda_old = sda_p[SYNC];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  // Data edges while the clock stays high are bus conditions.
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/twi_ptr.sv
`timescale 1ns/1ps
module twi_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (clr)   ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (inc)   ptr <= ptr + 1'b1;  // natural wrap at the top
  end
endmodule

// File: rtl/twi_proto.sv
`timescale 1ns/1ps
module twi_proto
  import twi_pkg::*;
#(
  parameter int         AW       = 6,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic              ptr_inc,
  output logic [AW-1:0]     ptr_val,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [BYTE_W-1:0] rd_data
);
  twi_st_e st, nxt;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] sr, tx, byte_in;
  logic              sub, byte_done;

  assign byte_in   = {sr[BYTE_W-2:0], sda_s};
  assign byte_done = scl_rise && (cnt == 3'd7) && !start_det && !stop_det && !pwr_fail;
  assign ptr_load  = byte_done && (st == ST_WADR);
  assign ptr_val   = byte_in[AW-1:0];
  assign ptr_inc   = !pwr_fail && ((wr_valid && wr_ready) || (rd_valid && rd_ready));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      sub <= 1'b0; sda_oe <= 1'b0; wr_valid <= 1'b0; rd_valid <= 1'b0; wr_data <= '0;
    end else if (pwr_fail) begin
      st <= ST_IDLE; sub <= 1'b0; sda_oe <= 1'b0;
      wr_valid <= 1'b0; rd_valid <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        tx       <= rd_data;
      end
      if (start_det) begin
        st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0; sub <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0; sub <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_WADR, ST_WDAT: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              sub <= 1'b0;
              st  <= ST_ACK;
              if (st == ST_DEV) begin
                if (byte_in[7:1] != DEV_ADDR) st <= ST_IDLE;
                else if (byte_in[0]) begin
                  nxt <= ST_RDAT;
                  rd_valid <= 1'b1;  // prefetch first read byte
                end else nxt <= ST_WADR;
              end else begin
                nxt <= ST_WDAT;
                if (st == ST_WDAT) begin
                  wr_data  <= byte_in;
                  wr_valid <= 1'b1;
                end
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!sub) begin
              sda_oe <= 1'b1;
              sub    <= 1'b1;
            end else begin
              sub    <= 1'b0;
              cnt    <= '0;
              st     <= nxt;
              sda_oe <= (nxt == ST_RDAT) ? ~tx[BYTE_W-1] : 1'b0;
            end
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              sub    <= 1'b0;
              st     <= ST_RACK;
            end else begin
              cnt    <= cnt + 1'b1;
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise && !sub) begin
              if (!sda_s) begin
                rd_valid <= 1'b1;
                sub      <= 1'b1;
              end else st <= ST_WAIT;
            end
            if (scl_fall && sub) begin
              sub    <= 1'b0;
              cnt    <= '0;
              sda_oe <= ~tx[BYTE_W-1];
              st     <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_regfile_slave.sv
`timescale 1ns/1ps
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter int         AW       = 6,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwr_fail,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  logic scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val, ptr;

  twi_line_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_proto #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .sda_oe(sda_oe), .ptr_load(ptr_load), .ptr_inc(ptr_inc), .ptr_val(ptr_val),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  twi_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(pwr_fail), .load(ptr_load),
    .load_val(ptr_val), .inc(ptr_inc), .ptr(ptr)
  );

  assign wr_addr = ptr;
  assign rd_addr = ptr;
endmodule

// File: rtl/twi_regfile_slave_chk.sv
`timescale 1ns/1ps
module twi_regfile_slave_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_plus;
  assign ptr_plus = ptr + 1'b1;

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !pwr_fail) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !pwr_fail) |=> (rd_valid && $stable(rd_addr)));

  assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));

  assert_pf_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_oe && !wr_valid && !rd_valid && ptr == '0));

  // also covers the wrap of R7
  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !pwr_fail) |=> (ptr == $past(ptr_plus)));

  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !pwr_fail) |=> (ptr == $past(ptr_plus)));

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_fail && !$past(pwr_fail) && (sda_oe != $past(sda_oe))) |-> !scl_i);
endmodule

bind twi_regfile_slave twi_regfile_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .pwr_fail(pwr_fail), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .ptr(ptr)
);

// File: tb/sim_twi_regfile_slave.sv
`timescale 1ns/1ps
module sim_twi_regfile_slave;
  localparam int AW = 6;
  localparam int DEPTH = 64;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h68;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, pwr_fail = 1'b0;
  logic wr_ready = 1'b0, rd_ready = 1'b0, force_stall = 1'b0;
  logic sda_oe, wr_valid, rd_valid;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [AW-1:0] exp_ptr = '0;
  int nchk = 0, nerr = 0, wwait = 0, rwait = 0;

  twi_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 3 + 1);
  endfunction
  function automatic bit addr_match(input logic [7:0] b);
    return b[7:1] == DEV;
  endfunction

  // register file model on the two streams
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
    else if (wr_valid && wr_ready) mem[wr_addr] <= wr_data;
  end
  assign rd_data = mem[rd_addr];

  always @(negedge clk) begin
    if (!wr_valid || force_stall) begin wr_ready = 1'b0; if (!wr_valid) wwait = $urandom % 4; end
    else if (wwait == 0) wr_ready = 1'b1;
    else begin wr_ready = 1'b0; wwait--; end
    if (!rd_valid) begin rd_ready = 1'b0; rwait = $urandom % 3; end
    else if (rwait == 0) rd_ready = 1'b1;
    else begin rd_ready = 1'b0; rwait--; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda = b; waitq(); m_scl = 1'b1; waitq(); s = sda_line; waitq(); m_scl = 1'b0; waitq();
  endtask
  task automatic bus_start();
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq(); waitq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); b[i] = s; end
    bus_bit(!mack, s);
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack == addr_match({DEV, 1'b0}), "R2 write addr ack", ack, 1);
    send_byte(8'(a), ack); chk(ack, "R3 pointer byte ack", ack, 1);
    exp_ptr = a;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, "R4 data ack", ack, 1);
      exp_mem[exp_ptr] = d; exp_ptr = exp_ptr + 1'b1;
    end
    bus_stop();
    mem_cmp("R4 written contents");
  endtask

  task automatic do_read(input bit set_addr, input logic [AW-1:0] a, input int n, input bit extra);
    logic ack; logic [7:0] b;
    bus_start();
    if (set_addr) begin
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'(a), ack); chk(ack, "R3 pointer byte ack", ack, 1);
      exp_ptr = a;
      bus_start();  // repeated START
    end
    send_byte({DEV, 1'b1}, ack); chk(ack, "R8 read addr ack after restart", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == exp_mem[exp_ptr], "R5 read data", b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    if (extra) begin
      recv_byte(1'b1, b); chk(b == 8'hFF, "R6 silent after NACK", b, 255);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic ack; logic [7:0] b;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
    chk(!wr_valid && !rd_valid, "R10 reset requests", wr_valid + rd_valid, 0);

    // plain write then read back with repeated START
    do_write(6'd5, 4);
    do_read(1'b1, 6'd5, 4, 1'b0);

    // wrong device addresses
    bus_start();
    send_byte(8'hA0, ack); chk(ack == addr_match(8'hA0), "R2 foreign addr no ack", ack, 0);
    send_byte(8'h07, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_start();
    send_byte(8'hD2, ack); chk(ack == addr_match(8'hD2), "R2 near-miss addr", ack, 0);
    bus_stop();
    mem_cmp("R2 no write on mismatch");

    // STOP returns idle: bytes with no START are ignored
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R1 idle after stop", ack, 0);
    send_byte(8'h11, ack); chk(!ack, "R1 idle after stop", ack, 0);
    mem_cmp("R1 no write while idle");

    // wrap of the pointer
    do_write(6'd62, 3);
    chk(exp_ptr == 6'd1, "R7 model wrap", exp_ptr, 1);
    do_read(1'b0, 6'd0, 2, 1'b1);
    do_read(1'b1, 6'd63, 2, 1'b1);

    // power fail with a write still waiting for ready
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd30, ack);
    force_stall = 1'b1;
    send_byte(8'h5A, ack); chk(ack, "R4 data ack before abort", ack, 1);
    chk(wr_valid, "R10 request held while stalled", wr_valid, 1);
    pwr_fail = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_valid && !sda_oe, "R9 abort drops request", wr_valid, 0);
    force_stall = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(!ack, "R9 deaf during power fail", ack, 0);
    bus_stop();
    pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    mem_cmp("R9 aborted write lost");
    exp_ptr = '0;
    do_read(1'b0, 6'd0, 2, 1'b0);
    chk(exp_ptr == 6'd2, "R9 read began at zero", exp_ptr, 2);

    // constrained random traffic
    for (int t = 0; t < 30; t++) begin
      case ($urandom % 3)
        0: do_write(AW'($urandom), 1 + $urandom % 5);
        1: do_read(1'b1, AW'($urandom), 1 + $urandom % 5, 1'b0);
        default: do_read(1'b0, 6'd0, 1 + $urandom % 4, ($urandom % 2) == 1);
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule